// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

This block is a general-purpose I/O port of up to 32 pins with eight word-wide registers. Software writes output values and per-pin direction, reads back the synchronised pad levels, and picks for every pin the condition that raises its interrupt flag. The condition can be a low level, a high level, a rising edge or a falling edge. A second per-pin control turns on detection of both edges instead.

Each pin's flag is sticky and is cleared by writing a one to it. Flags are gated by a per-pin enable. The enabled flags are ORed into two request lines: one serves the lower half of the port and one serves the upper half. Pad inputs pass through a flop chain before any detection. An edge is found by comparing the synchronised level with its value one clock earlier.

Top module: `gpio_port`

## Requirements
- R1: While and right after reset, every register reads 0, `pad_oe` and `pad_out` are 0, and both request lines are low.
- R2: `pad_oe[i]` follows direction bit i, where 1 means output. `pad_out` follows the output-value register, and that register reads back what was written.
- R3: The pad-level register shows `pad_in` delayed by exactly two clocks, with `SYNC_STAGES` = 2.
- R4: Sense code 2'b00 flags a pin on every clock its synchronised level is 0, and code 2'b01 does so while the level is 1. A flag cleared while its condition still holds is set again.
- R5: Sense code 2'b10 flags a pin once per 0-to-1 transition, and code 2'b11 does so once per 1-to-0 transition. A steady level after the transition does not flag the pin again.
- R6: Pins 0..15 take their code from the low-half sense register, bits [2i+1:2i]. Pins 16..31 take theirs from the high-half sense register, bits [2(i-16)+1:2(i-16)].
- R7: When a pin's both-edges bit is 1, that pin flags on either transition and its 2-bit code has no effect.
- R8: A flag latches whether or not its enable bit is set. A pin whose enable bit is 0 never drives a request line.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it as it was. Flags hold until they are cleared.
- R10: When a detection and a clearing write reach the same flag in one clock, the flag stays set.
- R11: `irq_lo` is the OR of enabled flags of pins 0..15, and `irq_hi` is the OR of enabled flags of pins 16..31. Each reacts in the cycle after the flag or enable changes.
- R12: Word index on `reg_addr` selects the register: 0 output value, 1 direction, 2 pad level (read-only, writes ignored), 3 low-half sense, 4 high-half sense, 5 interrupt enable, 6 flags, 7 both-edges. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Output values to pads |
| pad_oe | output | NPINS | Output enables to pads |
| irq_lo | output | 1 | Request for the lower half of the pins |
| irq_hi | output | 1 | Request for the upper half of the pins |

## Verification
The bench builds the port with its defaults: 32 pins and a two-flop synchroniser. Using 32 pins puts the split between the two sense registers and the two request lines at pin 16, so pins on both sides of it can be tested against each other. The two-stage chain fixes the pad-to-flag latency at three clocks, and each check samples at that point. This makes it possible to test a clear and a detection landing in the same clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int REG_IDX_W = 3;
   localparam int BUS_W     = 32;

   typedef enum logic [REG_IDX_W-1:0] {
      RG_OUTV  = 3'd0,
      RG_DIR   = 3'd1,
      RG_LEVEL = 3'd2,
      RG_SNSLO = 3'd3,
      RG_SNSHI = 3'd4,
      RG_ENA   = 3'd5,
      RG_FLAG  = 3'd6,
      RG_BOTH  = 3'd7
   } reg_sel_e;

   typedef enum logic [1:0] {
      SN_LOW  = 2'd0,
      SN_HIGH = 2'd1,
      SN_RISE = 2'd2,
      SN_FALL = 2'd3
   } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[k] <= '0;
            else        chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
   import gpio_port_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   lvl,
   input  sense_e code,
   input  logic   both,
   output logic   hit
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      if (both) hit = rise | fall;
      else begin
         unique case (code)
            SN_LOW:  hit = ~lvl;
            SN_HIGH: hit = lvl;
            SN_RISE: hit = rise;
            SN_FALL: hit = fall;
            default: hit = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int NPINS = 32,
   localparam int SNS_W = NPINS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [REG_IDX_W-1:0] idx,
   input  logic [BUS_W-1:0]     wdata,
   input  logic [NPINS-1:0]     lvl,
   input  logic [NPINS-1:0]     evt,
   output logic [NPINS-1:0]     outv_q,
   output logic [NPINS-1:0]     dir_q,
   output logic [SNS_W-1:0]     snslo_q,
   output logic [SNS_W-1:0]     snshi_q,
   output logic [NPINS-1:0]     ena_q,
   output logic [NPINS-1:0]     both_q,
   output logic [NPINS-1:0]     flag_q,
   output logic [BUS_W-1:0]     rdata
);
   reg_sel_e          sel;
   logic [NPINS-1:0]  wpins;
   logic [NPINS-1:0]  clr;

   assign sel   = reg_sel_e'(idx);
   assign wpins = wdata[NPINS-1:0];
   assign clr   = (wr && sel == RG_FLAG) ? wpins : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outv_q  <= '0;
         dir_q   <= '0;
         snslo_q <= '0;
         snshi_q <= '0;
         ena_q   <= '0;
         both_q  <= '0;
      end else if (wr) begin
         unique case (sel)
            RG_OUTV:  outv_q  <= wpins;
            RG_DIR:   dir_q   <= wpins;
            RG_SNSLO: snslo_q <= wdata[SNS_W-1:0];
            RG_SNSHI: snshi_q <= wdata[SNS_W-1:0];
            RG_ENA:   ena_q   <= wpins;
            RG_BOTH:  both_q  <= wpins;
            default:  ;
         endcase
      end
   end

   // detection outranks a clear of the same bit
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr) | evt;

   always_comb begin
      unique case (sel)
         RG_OUTV:  rdata = BUS_W'(outv_q);
         RG_DIR:   rdata = BUS_W'(dir_q);
         RG_LEVEL: rdata = BUS_W'(lvl);
         RG_SNSLO: rdata = BUS_W'(snslo_q);
         RG_SNSHI: rdata = BUS_W'(snshi_q);
         RG_ENA:   rdata = BUS_W'(ena_q);
         RG_FLAG:  rdata = BUS_W'(flag_q);
         RG_BOTH:  rdata = BUS_W'(both_q);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int HALF       = NPINS / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]     reg_wdata,
   output logic [BUS_W-1:0]     reg_rdata,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic                 irq_lo,
   output logic                 irq_hi
);
   if (NPINS < 2 || NPINS > BUS_W || (NPINS % 2) != 0) begin : g_bad_npins
      $error("gpio_port: NPINS must be even and within 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] lvl_s;
   logic [NPINS-1:0] evt_v;
   logic [NPINS-1:0] outv_q, dir_q, ena_q, both_q, stat_q;
   logic [NPINS-1:0] snslo_q, snshi_q;
   logic [NPINS-1:0] live;

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_s)
   );

   gpio_regfile #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_addr),
      .wdata(reg_wdata), .lvl(lvl_s), .evt(evt_v),
      .outv_q(outv_q), .dir_q(dir_q), .snslo_q(snslo_q), .snshi_q(snshi_q),
      .ena_q(ena_q), .both_q(both_q), .flag_q(stat_q), .rdata(reg_rdata)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      sense_e code;
      if (i < HALF) begin : g_lo
         assign code = sense_e'(snslo_q[2*i +: 2]);
      end else begin : g_hi
         assign code = sense_e'(snshi_q[2*(i-HALF) +: 2]);
      end
      gpio_sense u_sense (
         .clk(clk), .rst_n(rst_n), .lvl(lvl_s[i]), .code(code),
         .both(both_q[i]), .hit(evt_v[i])
      );
   end

   assign live    = stat_q & ena_q;
   assign irq_lo  = |live[HALF-1:0];
   assign irq_hi  = |live[NPINS-1:HALF];
   assign pad_out = outv_q;
   assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int NPINS = 32,
   localparam int HALF = NPINS / 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [REG_IDX_W-1:0] reg_addr,
   input logic [BUS_W-1:0]     reg_wdata,
   input logic [NPINS-1:0]     pad_oe,
   input logic                 irq_lo,
   input logic                 irq_hi,
   input logic [NPINS-1:0]     ena_q,
   input logic [NPINS-1:0]     stat_q,
   input logic [NPINS-1:0]     evt_v
);
   logic wr_dir, wr_flag;
   assign wr_dir  = reg_wr && reg_addr == RG_DIR;
   assign wr_flag = reg_wr && reg_addr == RG_FLAG;

   AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == $past(reg_wdata[NPINS-1:0])); // R2
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flag |=> (stat_q & $past(reg_wdata[NPINS-1:0] & ~evt_v)) == '0); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R9
   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_v != '0) |=> (stat_q & $past(evt_v)) == $past(evt_v)); // R10
   AST_LO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q[HALF-1:0] == '0) |-> !irq_lo); // R8
   AST_HI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q[NPINS-1:HALF] == '0) |-> !irq_hi); // R8
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
   .ena_q(ena_q), .stat_q(stat_q), .evt_v(evt_v)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
   import gpio_port_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq_lo, irq_hi;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   gpio_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   typedef struct packed {
      logic [2:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam vec_t VT [10] = '{
      '{3'd0, 32'h1234_5678, 32'h1234_5678},
      '{3'd1, 32'h0000_FFFF, 32'h0000_FFFF},
      '{3'd3, 32'hAAAA_AAAA, 32'hAAAA_AAAA},
      '{3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA},
      '{3'd5, 32'h8000_0001, 32'h8000_0001},
      '{3'd5, 32'h0000_0000, 32'h0000_0000},
      '{3'd7, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      '{3'd7, 32'h0000_0000, 32'h0000_0000},
      '{3'd2, 32'hFFFF_FFFF, 32'h0000_0000},
      '{3'd0, 32'h1234_5678, 32'h1234_5678}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      // R1 reset state
      waitn(2);
      chk("R1 oe", pad_oe, 32'h0);
      chk("R1 out", pad_out, 32'h0);
      chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
      for (int k = 0; k < 8; k++) begin
         rd(3'(k), v);
         chk("R1 reg", v, 32'h0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 / R2 register table
      for (int k = 0; k < 10; k++) begin
         wr(VT[k].a, VT[k].d);
         rd(VT[k].a, v);
         chk("R12 table", v, VT[k].e);
      end
      chk("R2 oe", pad_oe, 32'h0000_FFFF);
      chk("R2 out", pad_out, 32'h1234_5678);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, v);
      chk("R9 clear all", v, 32'h0);
      chk("R11 idle", {30'h0, irq_hi, irq_lo}, 32'h0);

      // R3 two-clock synchroniser latency on pin 8
      pad_in[8] = 1'b1;
      rd(3'd2, v); chk("R3 t0", v, 32'h0);
      waitn(1); rd(3'd2, v); chk("R3 t1", v, 32'h0);
      waitn(1); rd(3'd2, v); chk("R3 t2", v, 32'h0000_0100);
      pad_in[8] = 1'b0;
      waitn(3);
      wr(3'd6, 32'hFFFF_FFFF);

      // R4 high level on pin 3, R10 set beats clear
      wr(3'd3, 32'hAAAA_AA6A);
      pad_in[3] = 1'b1;
      waitn(3);
      rd(3'd6, v); chk("R4 high set", v & 32'h8, 32'h8);
      wr(3'd6, 32'h8);
      rd(3'd6, v); chk("R10 set wins", v & 32'h8, 32'h8);
      pad_in[3] = 1'b0;
      waitn(3);
      wr(3'd6, 32'h8);
      waitn(2);
      rd(3'd6, v); chk("R4 high quiet when low", v & 32'h8, 32'h0);
      wr(3'd3, 32'hAAAA_AA2A);
      waitn(1);
      wr(3'd6, 32'h8);
      rd(3'd6, v); chk("R4 low level reasserts", v & 32'h8, 32'h8);
      wr(3'd3, 32'hAAAA_AAAA);
      wr(3'd6, 32'hFFFF_FFFF);

      // R5 rising then falling on pin 20
      pad_in[20] = 1'b1;
      waitn(3);
      rd(3'd6, v); chk("R5 rise set", v & 32'h0010_0000, 32'h0010_0000);
      wr(3'd6, 32'h0010_0000);
      waitn(3);
      rd(3'd6, v); chk("R5 rise once", v & 32'h0010_0000, 32'h0);
      pad_in[20] = 1'b0;
      waitn(3);
      rd(3'd6, v); chk("R5 rise ignores fall", v & 32'h0010_0000, 32'h0);
      wr(3'd4, 32'hAAAA_ABAA);
      pad_in[20] = 1'b1;
      waitn(3);
      rd(3'd6, v); chk("R5 fall ignores rise", v & 32'h0010_0000, 32'h0);
      pad_in[20] = 1'b0;
      waitn(3);
      rd(3'd6, v); chk("R5 fall set", v & 32'h0010_0000, 32'h0010_0000);
      wr(3'd4, 32'hAAAA_AAAA);
      wr(3'd6, 32'hFFFF_FFFF);

      // R7 both edges on pin 5, code stays falling-only would miss the rise
      wr(3'd3, 32'hAAAA_AEAA);
      wr(3'd7, 32'h20);
      pad_in[5] = 1'b1;
      waitn(3);
      rd(3'd6, v); chk("R7 rise", v & 32'h20, 32'h20);
      wr(3'd6, 32'h20);
      pad_in[5] = 1'b0;
      waitn(3);
      rd(3'd6, v); chk("R7 fall", v & 32'h20, 32'h20);
      wr(3'd7, 32'h0);
      wr(3'd3, 32'hAAAA_AAAA);
      wr(3'd6, 32'hFFFF_FFFF);

      // R6 pin 16 high-level in high register, pin 0 left rising
      wr(3'd4, 32'hAAAA_AAA9);
      pad_in[0] = 1'b1; pad_in[16] = 1'b1;
      waitn(4);
      wr(3'd6, 32'h0001_0001);
      rd(3'd6, v); chk("R6 split", v & 32'h0001_0001, 32'h0001_0000);
      pad_in[0] = 1'b0; pad_in[16] = 1'b0;
      wr(3'd4, 32'hAAAA_AAAA);
      waitn(3);
      wr(3'd6, 32'hFFFF_FFFF);

      // R8 / R11 / R9 enables and request lines
      pad_in[2] = 1'b1;
      waitn(3);
      rd(3'd6, v); chk("R8 latch while disabled", v & 32'h4, 32'h4);
      chk("R8 no irq", {30'h0, irq_hi, irq_lo}, 32'h0);
      wr(3'd5, 32'h4);
      chk("R11 lo", {30'h0, irq_hi, irq_lo}, 32'h1);
      pad_in[30] = 1'b1;
      waitn(3);
      chk("R11 hi masked", {30'h0, irq_hi, irq_lo}, 32'h1);
      wr(3'd5, 32'h4000_0004);
      chk("R11 both", {30'h0, irq_hi, irq_lo}, 32'h3);
      wr(3'd6, 32'h4);
      rd(3'd6, v); chk("R9 partial clear", v & 32'h4000_0004, 32'h4000_0000);
      chk("R11 hi only", {30'h0, irq_hi, irq_lo}, 32'h2);
      wr(3'd6, 32'h4000_0000);
      chk("R11 none", {30'h0, irq_hi, irq_lo}, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule